// File: doc/BRIEF.md
# PCM Receive Word FIFO

This block sits at the tail of an audio decimation chain. Each cycle in which the chain presents a signed 24-bit PCM sample, the block converts it into a 32-bit word of a selected width, filling the unused upper bits with either zeros or copies of the sign, and stores the word in a 64-entry first-in first-out queue. A reader sees the oldest stored word at all times on a data output. It removes that word with a one-cycle pop strobe, or leaves it in place simply by looking without popping. The current fill level is always visible.

Three sticky status bits record events: the fill level rising above a 6-bit threshold, a sample arriving while the queue is full, and a pop while the queue is empty. Each bit can be cleared by writing 1 or forced by a set strobe. A masked OR of the bits drives one interrupt line. A freeze input holds the queue exactly as it is so that it can be inspected during debug.

Top module: `pcm_rx_fifo`

## Requirements
- R1: The queue holds up to 64 words and returns them in arrival order. `fill_level` reports the number stored, from 0 to 64.
- R2: `cfg_wsize` selects the word width: 0→8, 1→10, 2→12, 3→14, 4→16, 5→18, 6→20, 7→24 and 8→32 bits. Codes 9 to 15 behave like 8. For widths up to 24 bits the word is the top bits of the sample, right-aligned. For code 8 the whole sample sits in bits 23:0.
- R3: With `cfg_sext`=0 every bit above the chosen width is 0. With `cfg_sext`=1 every such bit copies the sample's sign bit (bit 23).
- R4: A sample offered while 64 words are stored is dropped. The level stays 64, and status bit 1 (overflow) is set at that clock edge.
- R5: A pop while the queue is empty leaves the level at 0 and sets status bit 2 (underflow) at that clock edge.
- R6: Status bit 0 (trigger) becomes 1 one cycle after `fill_level` exceeds `cfg_trig_lvl`. It does not become 1 while the level is at or below the threshold.
- R7: `rd_data` shows the oldest stored word. Observing it without `rd_pop` changes neither the data nor the level.
- R8: While `freeze` is 1, offered samples and pops have no effect on the stored words or the level, and neither sets overflow nor underflow.
- R9: A 1 on a bit of `st_clr` clears that status bit, and a 1 on a bit of `st_set` sets it. When a set or a new event coincides with a clear on the same bit, the bit ends up 1.
- R10: `irq` is 1 exactly when some status bit and the matching `irq_mask` bit are both 1.
- R11: After reset the level is 0, all status bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_data | input | 24 | Signed PCM sample |
| cfg_wsize | input | 4 | Word-width code |
| cfg_sext | input | 1 | 1: sign extension, 0: zero extension |
| cfg_trig_lvl | input | 6 | Trigger threshold |
| freeze | input | 1 | Debug hold of the queue |
| rd_pop | input | 1 | Remove the head word |
| rd_data | output | 32 | Head word |
| fill_level | output | 7 | Number of stored words |
| st_set | input | 3 | Force status bits (bit0 trigger, bit1 overflow, bit2 underflow) |
| st_clr | input | 3 | Clear status bits, same bit order |
| irq_mask | input | 3 | Interrupt enable per status bit |
| irq_status | output | 3 | Sticky status bits |
| irq | output | 1 | Masked interrupt |

## Verification
Some properties are checked by assertions on every cycle: the level stays within bounds, a full or frozen queue holds its level, overflow, underflow and trigger events leave their status bit set one edge later, and a lone clear drops its bit. The bench's scenarios are needed for the rest. They show the width and extension patterns of the formatter across many codes, the preservation of arrival order through a full wrap of the storage, and the head staying unchanged during peeks and freezes. They also show the priority of set over clear and the masking of the interrupt line.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

    localparam int SMP_W  = 24;
    localparam int WORD_W = 32;

    // status bit positions
    localparam int ST_TRIG = 0;
    localparam int ST_OVF  = 1;
    localparam int ST_UDF  = 2;
    localparam int ST_W    = 3;

    typedef enum logic [3:0] {
        WS_8  = 4'd0,
        WS_10 = 4'd1,
        WS_12 = 4'd2,
        WS_14 = 4'd3,
        WS_16 = 4'd4,
        WS_18 = 4'd5,
        WS_20 = 4'd6,
        WS_24 = 4'd7,
        WS_32 = 4'd8
    } wsize_e;

    // event vector, trigger in the lowest bit
    typedef struct packed {
        logic udf;
        logic ovf;
        logic trig;
    } st_vec_t;

    // number of sample bits kept in the word for a width code
    function automatic int unsigned kept_bits(input logic [3:0] code);
        case (code)
            WS_8:    kept_bits = 8;
            WS_10:   kept_bits = 10;
            WS_12:   kept_bits = 12;
            WS_14:   kept_bits = 14;
            WS_16:   kept_bits = 16;
            WS_18:   kept_bits = 18;
            WS_20:   kept_bits = 20;
            default: kept_bits = 24;
        endcase
    endfunction

endpackage

// File: rtl/pcmrx_fmt.sv
module pcmrx_fmt
    import pcmrx_pkg::*;
(
    input  logic [SMP_W-1:0]  sample,
    input  logic [3:0]        code,
    input  logic              sext,
    output logic [WORD_W-1:0] word
);
    localparam int EXT_W = WORD_W - SMP_W;

    logic signed [WORD_W-1:0] widened;
    logic signed [WORD_W-1:0] aligned;
    logic        [WORD_W-1:0] keep_mask;
    int unsigned              nbits;

    always_comb begin
        nbits     = kept_bits(code);
        widened   = $signed({{EXT_W{sample[SMP_W-1]}}, sample});
        // drop the low bits so that the top nbits land right-aligned
        aligned   = widened >>> (SMP_W - nbits);
        keep_mask = (WORD_W'(1) << nbits) - WORD_W'(1);
        word      = sext ? aligned : (aligned & keep_mask);
    end

endmodule

// File: rtl/pcmrx_store.sv
module pcmrx_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_req,
    input  logic [DATA_W-1:0]         wr_word,
    input  logic                      rd_req,
    input  logic                      freeze,
    output logic [DATA_W-1:0]         head,
    output logic [$clog2(DEPTH):0]    count,
    output logic                      ovf_evt,
    output logic                      udf_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, empty, do_wr, do_rd;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_wr   = wr_req && !freeze && !full;
    assign do_rd   = rd_req && !freeze && !empty;
    assign ovf_evt = wr_req && !freeze && full;
    assign udf_evt = rd_req && !freeze && empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R1: the level never passes the depth
    p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R4: a write into a full queue without a pop leaves it full
    p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full && !rd_req && !freeze) |=> (count == FULL_CNT));

    // R5: a pop on an empty queue without a write leaves it empty
    p_empty_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty && !wr_req) |=> (count == '0));

    // R8: freeze holds the level
    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(count));

endmodule

// File: rtl/pcmrx_irq.sv
module pcmrx_irq
    import pcmrx_pkg::*;
#(
    parameter int CW = 7,
    parameter int TW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   level,
    input  logic [TW-1:0]   trig_lvl,
    input  logic            ovf_evt,
    input  logic            udf_evt,
    input  logic [ST_W-1:0] set_bits,
    input  logic [ST_W-1:0] clr_bits,
    input  logic [ST_W-1:0] mask,
    output logic [ST_W-1:0] status,
    output logic            irq_line
);
    st_vec_t evt;

    always_comb begin
        evt.trig = (level > CW'(trig_lvl));
        evt.ovf  = ovf_evt;
        evt.udf  = udf_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_bits) | evt | set_bits;
    end

    assign irq_line = |(status & mask);

    // R6: trigger condition is recorded at the next edge
    p_trig_set_r6: assert property (@(posedge clk) disable iff (rst)
        (level > CW'(trig_lvl)) |=> status[ST_TRIG]);

    // R4: overflow event is recorded
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> status[ST_OVF]);

    // R5: underflow event is recorded
    p_udf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        udf_evt |=> status[ST_UDF]);

    // R9: a clear with no competing set or event drops the bit
    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_bits[ST_OVF] && !set_bits[ST_OVF] && !ovf_evt) |=> !status[ST_OVF]);

endmodule

// File: rtl/pcm_rx_fifo.sv
module pcm_rx_fifo
    import pcmrx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [3:0]        cfg_wsize,
    input  logic              cfg_sext,
    input  logic [AW-1:0]     cfg_trig_lvl,
    input  logic              freeze,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] rd_data,
    output logic [CW-1:0]     fill_level,
    input  logic [ST_W-1:0]   st_set,
    input  logic [ST_W-1:0]   st_clr,
    input  logic [ST_W-1:0]   irq_mask,
    output logic [ST_W-1:0]   irq_status,
    output logic              irq
);
    logic [WORD_W-1:0] fmt_word;
    logic              ovf_evt, udf_evt;

    pcmrx_fmt u_fmt (
        .sample (smp_data),
        .code   (cfg_wsize),
        .sext   (cfg_sext),
        .word   (fmt_word)
    );

    pcmrx_store #(.DEPTH(DEPTH), .DATA_W(WORD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (smp_valid),
        .wr_word (fmt_word),
        .rd_req  (rd_pop),
        .freeze  (freeze),
        .head    (rd_data),
        .count   (fill_level),
        .ovf_evt (ovf_evt),
        .udf_evt (udf_evt)
    );

    pcmrx_irq #(.CW(CW), .TW(AW)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .level    (fill_level),
        .trig_lvl (cfg_trig_lvl),
        .ovf_evt  (ovf_evt),
        .udf_evt  (udf_evt),
        .set_bits (st_set),
        .clr_bits (st_clr),
        .mask     (irq_mask),
        .status   (irq_status),
        .irq_line (irq)
    );

    // R8: no error status is raised by activity while frozen
    p_freeze_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (freeze && !st_set[ST_OVF] && !irq_status[ST_OVF]) |=> !irq_status[ST_OVF]);

endmodule

// File: tb/pcm_rx_fifo_tb.sv
module pcm_rx_fifo_tb_top;

    typedef struct packed {
        logic [23:0] smp;
        logic [3:0]  code;
        logic        sx;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    // formatting vectors: R2 width selection, R3 extension
    localparam vec_t VECS [NV] = '{
        '{24'h800001, 4'd0, 1'b0, 32'h00000080},
        '{24'h800001, 4'd0, 1'b1, 32'hFFFFFF80},
        '{24'h7FFFFF, 4'd0, 1'b1, 32'h0000007F},
        '{24'hABCDEF, 4'd4, 1'b0, 32'h0000ABCD},
        '{24'hABCDEF, 4'd4, 1'b1, 32'hFFFFABCD},
        '{24'hABCDEF, 4'd1, 1'b0, 32'h000002AF},
        '{24'hABCDEF, 4'd1, 1'b1, 32'hFFFFFEAF},
        '{24'h123456, 4'd7, 1'b1, 32'h00123456},
        '{24'h923456, 4'd8, 1'b1, 32'hFF923456},
        '{24'h923456, 4'd8, 1'b0, 32'h00923456},
        '{24'h923456, 4'd2, 1'b1, 32'hFFFFF923},
        '{24'h4C0000, 4'd3, 1'b1, 32'h00001300},
        '{24'hF00000, 4'd5, 1'b0, 32'h0003C000},
        '{24'h80000F, 4'd6, 1'b1, 32'hFFF80000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic [3:0]  cfg_wsize = 4'd7;
    logic        cfg_sext = 1'b0;
    logic [5:0]  cfg_trig_lvl = 6'd63;
    logic        freeze = 1'b0;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_data;
    logic [6:0]  fill_level;
    logic [2:0]  st_set = '0;
    logic [2:0]  st_clr = '0;
    logic [2:0]  irq_mask = '0;
    logic [2:0]  irq_status;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pcm_rx_fifo dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_wsize(cfg_wsize), .cfg_sext(cfg_sext), .cfg_trig_lvl(cfg_trig_lvl),
        .freeze(freeze), .rd_pop(rd_pop), .rd_data(rd_data), .fill_level(fill_level),
        .st_set(st_set), .st_clr(st_clr), .irq_mask(irq_mask),
        .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end right after a falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [23:0] s);
        smp_valid = 1'b1;
        smp_data  = s;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
    endtask

    task automatic clear_all();
        st_clr = 3'b111;
        tick();
        st_clr = 3'b000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] head_snap;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R11 reset state
        chk("R11 level", 32'(fill_level), 32'd0);
        chk("R11 status", 32'(irq_status), 32'd0);
        chk("R11 irq", 32'(irq), 32'd0);

        // vector table: push all, then pop and compare in order
        for (int i = 0; i < NV; i++) begin
            cfg_wsize = VECS[i].code;
            cfg_sext  = VECS[i].sx;
            push(VECS[i].smp);
        end
        chk("R1 level after table", 32'(fill_level), 32'(NV));
        for (int i = 0; i < NV; i++) begin
            chk($sformatf("R2/R3 vector %0d", i), rd_data, VECS[i].exp);
            pop();
        end
        chk("R1 level drained", 32'(fill_level), 32'd0);

        // R7 peek without pop
        cfg_wsize = 4'd7;
        cfg_sext  = 1'b0;
        push(24'h5A5A5A);
        repeat (3) tick();
        chk("R7 peek data", rd_data, 32'h005A5A5A);
        chk("R7 peek level", 32'(fill_level), 32'd1);
        pop();

        // R5 underflow
        clear_all();
        pop();
        chk("R5 level", 32'(fill_level), 32'd0);
        chk("R5 underflow bit", 32'(irq_status), 32'b100);

        // R9 clear
        clear_all();
        chk("R9 cleared", 32'(irq_status), 32'd0);

        // R6 trigger threshold
        cfg_trig_lvl = 6'd3;
        for (int i = 0; i < 3; i++) push(24'h100000 + 24'(i));
        tick();
        chk("R6 at threshold", 32'(irq_status[0]), 32'd0);
        push(24'h100003);
        tick();
        chk("R6 above threshold", 32'(irq_status[0]), 32'd1);
        // R10 masking
        irq_mask = 3'b110;
        tick();
        chk("R10 masked off", 32'(irq), 32'd0);
        irq_mask = 3'b001;
        tick();
        chk("R10 enabled", 32'(irq), 32'd1);
        irq_mask = 3'b000;

        // R4 fill and overflow
        for (int i = 4; i < 64; i++) push(24'h100000 + 24'(i));
        chk("R1 full level", 32'(fill_level), 32'd64);
        chk("R4 no overflow yet", 32'(irq_status[1]), 32'd0);
        push(24'hDEAD00);
        chk("R4 level held", 32'(fill_level), 32'd64);
        chk("R4 overflow bit", 32'(irq_status[1]), 32'd1);

        // R8 freeze
        st_clr = 3'b010;
        freeze = 1'b1;
        tick();
        st_clr = 3'b000;
        head_snap = rd_data;
        pop();
        chk("R8 pop level", 32'(fill_level), 32'd64);
        chk("R8 pop head", rd_data, head_snap);
        push(24'hBEEF00);
        chk("R8 push level", 32'(fill_level), 32'd64);
        chk("R8 no overflow", 32'(irq_status[1]), 32'd0);
        freeze = 1'b0;
        tick();

        // R1 drain in order through the wrap
        for (int i = 0; i < 64; i++) begin
            chk($sformatf("R1 order %0d", i), rd_data, 32'h00100000 + 32'(i));
            pop();
        end
        chk("R1 empty again", 32'(fill_level), 32'd0);

        // R9 set, and set beating clear
        clear_all();
        st_set = 3'b100;
        tick();
        st_set = 3'b000;
        chk("R9 forced bit", 32'(irq_status), 32'b100);
        st_set = 3'b010;
        st_clr = 3'b010;
        tick();
        st_set = 3'b000;
        st_clr = 3'b000;
        chk("R9 set over clear", 32'(irq_status[1]), 32'd1);

        // R11 reset mid-run
        push(24'h000001);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R11 reset level", 32'(fill_level), 32'd0);
        chk("R11 reset status", 32'(irq_status), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule